// File: doc/BRIEF.md
# DRAM Refresh and Initialization Controller

This block schedules refresh for an asynchronous DRAM. Out of reset it owns the RAS, CAS and WE strobes and keeps them inactive (high) for a programmable power-up pause. It then runs a fixed number of initialization refresh cycles, and only after that raises `init_done`. From then on a free-running interval timer creates one refresh demand per interval. The demand is shown to the access sequencer as `ref_req`. A missed interval is held pending rather than lost. When the sequencer answers with `ref_gnt`, the controller takes the strobes and runs one refresh cycle.

Two refresh flavours are supported, chosen by `ras_only_mode` at the start of each cycle. In the CAS-before-RAS flavour the DRAM supplies the row internally: CAS drops one clock ahead of RAS and stays low while RAS is low. In the RAS-only flavour CAS stays high and the controller drives a row number from an internal wrapping counter. All durations are given in clock cycles. With a 5 ns clock the defaults give a 200 us pause, a 60 ns RAS pulse, a 40 ns precharge and a 15.6 us interval.

The state machine has six states. ST_PWRUP holds off for the pause. ST_IDLE waits for a granted request. ST_SETUP is one cycle with all strobes high. ST_CAS_LEAD (CBR only) has CAS low while RAS is still high. ST_RAS_LOW holds RAS low. ST_PRECHG holds RAS high.

The transitions are:
- ST_PWRUP to ST_SETUP when the pause expires.
- ST_IDLE to ST_SETUP on pending and grant.
- ST_SETUP to ST_CAS_LEAD or ST_RAS_LOW, by mode.
- ST_CAS_LEAD to ST_RAS_LOW.
- ST_RAS_LOW to ST_PRECHG after RAS_LOW_CYC cycles.
- ST_PRECHG, after PRE_CYC cycles, to ST_SETUP while initialization cycles remain, otherwise to ST_IDLE.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset `strobe_own`=1, `ras_n`=`cas_n`=`we_n`=1, `init_done`=0 and `ref_req`=0, and RAS does not fall during the first PWRUP_CYC cycles.
- R2: Exactly INIT_CYCLES refresh cycles run before `init_done` rises. `init_done` then stays 1 until reset.
- R3: In a CAS-before-RAS cycle (`ras_only_mode`=0) CAS is low at least one cycle before RAS falls. RAS has been high at least one cycle when CAS falls. CAS stays low for the whole RAS-low time. `we_n` is never 0.
- R4: Every RAS-low pulse lasts exactly RAS_LOW_CYC cycles. Between refresh cycles RAS is high for at least PRE_CYC cycles.
- R5: In a RAS-only cycle (`ras_only_mode`=1) CAS stays high and `row_addr` carries the row counter, held stable while RAS is low. The row counter starts at 0 after reset and advances by one per RAS-only cycle, wrapping modulo 2^ROW_W.
- R6: After `init_done`, `ref_req` rises once every INTERVAL_CYC cycles when grants are immediate. It never rises before `init_done`, and once high it stays high until `ref_gnt` is seen.
- R7: With no grant the controller leaves the strobes released (`strobe_own`=0, RAS and CAS high). A grant during `ref_req` starts a refresh and sets `strobe_own`=1.
- R8: One grant yields exactly one refresh cycle and clears the request, even when more than one interval elapsed while it waited.
- R9: The mode is sampled once, in ST_SETUP. A change of `ras_only_mode` during a cycle does not alter that cycle's strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_only_mode | input | 1 | 1 = RAS-only refresh, 0 = CAS-before-RAS |
| ref_gnt | input | 1 | Sequencer grants the strobes for a refresh |
| ref_req | output | 1 | Refresh pending toward the sequencer |
| strobe_own | output | 1 | Controller currently drives the strobes |
| init_done | output | 1 | Power-up pause and initialization finished |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row number during RAS-only refresh, else 0 |

## Verification
The assertions guard the following on every cycle:
- CAS leads RAS in CBR cycles.
- RAS has been high before CAS falls.
- CAS stays high during RAS-only pulses.
- The row address is stable while RAS is low.
- No request appears before initialization, and a request persists until granted.
- `init_done` never drops.
- A request is cleared on a take.

The bench scenarios show what needs counting over long stretches: the power-up pause length, the exact number of initialization cycles, pulse and precharge widths, the interval period, the row sequence through its wrap, and that a long-waiting grant produces only a single cycle. They also show that a mode change in mid-cycle leaves that cycle intact.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_SETUP,
        ST_CAS_LEAD,
        ST_RAS_LOW,
        ST_PRECHG
    } ref_state_t;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int INTERVAL_CYC = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic take,
    output logic pending
);
    localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = en && (cnt == CW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (en) cnt <= wrap ? '0 : cnt + 1'b1;
            pending <= wrap | (pending & ~take);
        end
    end

    // R8: a take without a simultaneous new interval leaves nothing pending
    a_r8_take_clears: assert property (@(posedge clk) disable iff (rst)
        take && !wrap |=> !pending);
endmodule

// File: rtl/ref_row_counter.sv
module ref_row_counter #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst)      row <= '0;
        else if (inc) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dram_ref_pkg::*;
#(
    parameter int PWRUP_CYC    = 40000,
    parameter int INIT_CYCLES  = 8,
    parameter int INTERVAL_CYC = 3120,
    parameter int RAS_LOW_CYC  = 12,
    parameter int PRE_CYC      = 8,
    parameter int ROW_W        = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_only_mode,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             strobe_own,
    output logic             init_done,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr
);
    localparam int TW = $clog2(PWRUP_CYC + RAS_LOW_CYC + PRE_CYC + 1);
    localparam int IW = $clog2(INIT_CYCLES + 1);

    ref_state_t     state, nxt;
    logic [TW-1:0]  tcnt;
    logic [IW-1:0]  icnt;
    logic           init_q;
    logic           mode_q;
    logic           pending;
    logic           take;
    logic           row_inc;
    logic           pre_end;
    logic [ROW_W-1:0] row;

    assign take    = (state == ST_IDLE) && pending && ref_gnt;
    assign pre_end = (state == ST_PRECHG) && (tcnt == TW'(PRE_CYC - 1));
    assign row_inc = (state == ST_RAS_LOW) && (tcnt == TW'(RAS_LOW_CYC - 1)) && mode_q;

    ref_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (init_q),
        .take    (take),
        .pending (pending)
    );

    ref_row_counter #(.ROW_W(ROW_W)) u_rows (
        .clk (clk),
        .rst (rst),
        .inc (row_inc),
        .row (row)
    );

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PWRUP:    if (tcnt == TW'(PWRUP_CYC - 1)) nxt = ST_SETUP;
            ST_IDLE:     if (take) nxt = ST_SETUP;
            ST_SETUP:    nxt = ras_only_mode ? ST_RAS_LOW : ST_CAS_LEAD;
            ST_CAS_LEAD: nxt = ST_RAS_LOW;
            ST_RAS_LOW:  if (tcnt == TW'(RAS_LOW_CYC - 1)) nxt = ST_PRECHG;
            ST_PRECHG:   if (pre_end)
                             nxt = (!init_q && icnt != IW'(INIT_CYCLES - 1)) ? ST_SETUP : ST_IDLE;
            default:     nxt = ST_PWRUP;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_PWRUP;
            tcnt   <= '0;
            icnt   <= '0;
            init_q <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            state <= nxt;
            tcnt  <= (nxt != state) ? '0 : tcnt + 1'b1;
            if (state == ST_SETUP) mode_q <= ras_only_mode;
            if (pre_end && !init_q) begin
                icnt <= icnt + 1'b1;
                if (icnt == IW'(INIT_CYCLES - 1)) init_q <= 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        strobe_own = (state != ST_IDLE);
        ras_n      = (state != ST_RAS_LOW);
        cas_n      = !((state == ST_CAS_LEAD) || (state == ST_RAS_LOW && !mode_q));
        we_n       = 1'b1;
        row_addr   = (state == ST_RAS_LOW && mode_q) ? row : '0;
        ref_req    = (state == ST_IDLE) && pending;
        init_done  = init_q;
    end

    // R3: CAS is already low the cycle before RAS falls in a CBR cycle
    a_r3_cas_leads: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) && !mode_q |-> !cas_n && $past(!cas_n));
    // R3: RAS has been high at least one cycle when CAS falls
    a_r3_ras_precharged: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> ras_n && $past(ras_n));
    // R5: CAS stays high through a RAS-only pulse
    a_r5_cas_high: assert property (@(posedge clk) disable iff (rst)
        !ras_n && mode_q |-> cas_n);
    // R5: row address held while RAS is low
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
        !ras_n && $past(!ras_n) |-> $stable(row_addr));
    // R6: no request before initialization completes
    a_r6_no_early_req: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> init_done);
    // R6: an ungranted request persists
    a_r6_req_holds: assert property (@(posedge clk) disable iff (rst)
        ref_req && !ref_gnt |=> ref_req);
    // R2: initialization completion is sticky
    a_r2_init_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);
endmodule

// File: tb/tb_dram_refresh_ctrl.sv
`timescale 1ns/100ps
module tb_dram_refresh_ctrl;
    localparam int PW  = 50;
    localparam int NI  = 8;
    localparam int IV  = 60;
    localparam int RL  = 12;
    localparam int PC  = 8;
    localparam int RW  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_only_mode = 1'b0;
    logic auto_gnt = 1'b1;
    logic ref_gnt;
    logic ref_req, strobe_own, init_done, ras_n, cas_n, we_n;
    logic [RW-1:0] row_addr;

    int n_chk = 0;
    int n_bad = 0;

    assign ref_gnt = auto_gnt && ref_req;

    always #2.5 clk = ~clk;

    dram_refresh_ctrl #(
        .PWRUP_CYC(PW), .INIT_CYCLES(NI), .INTERVAL_CYC(IV),
        .RAS_LOW_CYC(RL), .PRE_CYC(PC), .ROW_W(RW)
    ) dut (
        .clk(clk), .rst(rst), .ras_only_mode(ras_only_mode), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .strobe_own(strobe_own), .init_done(init_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr)
    );

    // strobe monitor, sampled at the falling clock edge
    int cyc, falls, first_fall, min_pre, hi_run, low_len;
    int order_bad, rpc_bad, len_bad, addr_bad, we_bad;
    int req_rise, req_prev_rise, rises;
    logic prev_ras, prev_cas, prev_req;
    logic fall_cas_now, all_lo, all_hi, last_all_lo, last_all_hi;
    logic [RW-1:0] addr_fall;

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; falls = 0; first_fall = -1; min_pre = 1000000; hi_run = 0;
            low_len = 0; order_bad = 0; rpc_bad = 0; len_bad = 0; addr_bad = 0;
            we_bad = 0; req_rise = 0; req_prev_rise = 0; rises = 0;
            prev_ras = 1'b1; prev_cas = 1'b1; prev_req = 1'b0;
            all_lo = 1'b0; all_hi = 1'b0; last_all_lo = 1'b0; last_all_hi = 1'b0;
            fall_cas_now = 1'b1; addr_fall = '0;
        end else begin
            cyc++;
            if (prev_ras && !ras_n) begin
                falls++;
                if (falls == 1) first_fall = cyc;
                else if (hi_run < min_pre) min_pre = hi_run;
                if (!cas_n && prev_cas) order_bad++;
                fall_cas_now = cas_n;
                addr_fall = row_addr;
                low_len = 1;
                all_lo = !cas_n;
                all_hi = cas_n;
            end else if (!ras_n) begin
                low_len++;
                all_lo = all_lo && !cas_n;
                all_hi = all_hi && cas_n;
                if (row_addr != addr_fall) addr_bad++;
            end else if (!prev_ras && ras_n) begin
                if (low_len != RL) len_bad++;
                last_all_lo = all_lo;
                last_all_hi = all_hi;
                hi_run = 1;
            end else begin
                hi_run++;
            end
            if (prev_cas && !cas_n && !(ras_n && prev_ras)) rpc_bad++;
            if (!we_n) we_bad++;
            if (ref_req && !prev_req) begin
                req_prev_rise = req_rise;
                req_rise = cyc;
                rises++;
            end
            prev_ras = ras_n;
            prev_cas = cas_n;
            prev_req = ref_req;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_falls(input int target, input int limit);
        for (int i = 0; i < limit && falls < target; i++) tick(1);
    endtask

    task automatic wait_rise_done(input int limit);
        for (int i = 0; i < limit && !ras_n; i++) tick(1);
        tick(1);
    endtask

    task automatic t_reset_state;
        tick(3);
        chk(strobe_own == 1'b1, "R1", "own after reset", strobe_own, 1);
        chk(ras_n && cas_n && we_n, "R1", "strobes high after reset", {ras_n, cas_n, we_n}, 7);
        chk(init_done == 1'b0, "R1", "init_done after reset", init_done, 0);
        chk(ref_req == 1'b0, "R1", "ref_req after reset", ref_req, 0);
    endtask

    task automatic t_powerup_init;
        for (int i = 0; i < 2000 && !init_done; i++) begin
            chk(!ref_req, "R6", "req before init", ref_req, 0);
            tick(1);
        end
        chk(first_fall >= PW, "R1", "first RAS fall cycle", first_fall, PW);
        chk(falls == NI, "R2", "init cycle count", falls, NI);
        chk(order_bad == 0 && rpc_bad == 0, "R3", "CBR ordering faults", order_bad + rpc_bad, 0);
        chk(last_all_lo == 1'b1, "R3", "CAS low through RAS", last_all_lo, 1);
        chk(len_bad == 0, "R4", "RAS width faults", len_bad, 0);
        chk(min_pre >= PC, "R4", "min precharge", min_pre, PC);
    endtask

    task automatic t_interval;
        int r0 = rises;
        for (int i = 0; i < 4 * IV && rises < r0 + 2; i++) tick(1);
        chk(rises >= r0 + 2, "R6", "request rises seen", rises - r0, 2);
        chk(req_rise - req_prev_rise == IV, "R6", "request period", req_rise - req_prev_rise, IV);
        chk(init_done == 1'b1, "R2", "init_done sticky", init_done, 1);
    endtask

    task automatic t_pending;
        int f0, drops;
        auto_gnt = 1'b0;
        for (int i = 0; i < 3 * IV && !ref_req; i++) tick(1);
        tick(RL + PC + 4);
        f0 = falls;
        drops = 0;
        for (int i = 0; i < 2 * IV + 30; i++) begin
            tick(1);
            if (!ref_req) drops++;
        end
        chk(drops == 0, "R6", "request dropped while waiting", drops, 0);
        chk(falls == f0, "R7", "refresh without grant", falls - f0, 0);
        chk(!strobe_own && ras_n && cas_n, "R7", "strobes released", strobe_own, 0);
        auto_gnt = 1'b1;
        tick(1);
        auto_gnt = 1'b0;
        chk(strobe_own == 1'b1, "R7", "own after grant", strobe_own, 1);
        chk(ref_req == 1'b0, "R8", "request cleared by grant", ref_req, 0);
        tick(RL + PC + 10);
        chk(falls == f0 + 1, "R8", "cycles per grant", falls - f0, 1);
    endtask

    task automatic t_ras_only;
        int f0;
        ras_only_mode = 1'b1;
        auto_gnt = 1'b1;
        for (int k = 0; k < 18; k++) begin
            f0 = falls;
            wait_falls(f0 + 1, 3 * IV);
            chk(falls == f0 + 1, "R5", "RAS-only cycle seen", falls - f0, 1);
            chk(fall_cas_now == 1'b1, "R5", "CAS high at RAS fall", fall_cas_now, 1);
            chk(addr_fall == RW'(k), "R5", "row number", addr_fall, k % 16);
            wait_rise_done(3 * RL);
            chk(last_all_hi == 1'b1, "R5", "CAS high through pulse", last_all_hi, 1);
        end
        chk(addr_bad == 0, "R5", "row unstable during RAS low", addr_bad, 0);
    endtask

    task automatic t_mode_change;
        int f0;
        ras_only_mode = 1'b0;
        f0 = falls;
        wait_falls(f0 + 1, 3 * IV);
        ras_only_mode = 1'b1;
        wait_rise_done(3 * RL);
        chk(last_all_lo == 1'b1, "R9", "CBR cycle kept CAS low", last_all_lo, 1);
        f0 = falls;
        wait_falls(f0 + 1, 3 * IV);
        chk(fall_cas_now == 1'b1, "R9", "new mode at next cycle", fall_cas_now, 1);
        chk(addr_fall == RW'(18), "R5", "row continues after wrap", addr_fall, 2);
        wait_rise_done(3 * RL);
        chk(we_bad == 0, "R3", "WE low samples", we_bad, 0);
        chk(len_bad == 0 && min_pre >= PC, "R4", "width faults overall", len_bad, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        t_reset_state();
        t_powerup_init();
        t_interval();
        t_pending();
        t_ras_only();
        t_mode_change();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule